// File: doc/BRIEF.md
# Parallel-Port Nibble Register Interface

This block is the device-side end of a narrow host link: an 8-bit data path driven by the host and a 4-bit return path read back by the host on status lines. All traffic is coded into the data bytes. The three most significant bits of a byte are a command code. Bit 4 marks which half of a byte a nibble belongs to, and bits 3..0 carry either a register offset or a nibble of data. From these bytes the block latches a register offset and assembles nibble pairs into register writes. It also selects a register nibble to return, and turns streamed nibble pairs into byte writes to a packet buffer held outside the block.

The host holds each byte on the data lines for as long as it likes. The block passes the lines through a two-flop synchroniser and acts once for every change of the synchronised value, so a byte the host writes twice in a row has no further effect. The register file holds `NREGS` bytes. By convention offsets 0-5 hold the station address, 6-7 the transmit length, 8-9 the transmit and receive status, 10 the interrupt status and 11 the interrupt mask. The block gives no offset any special behaviour.

Top module: `ppn_regif`

## Requirements
- R1: While reset is asserted and directly after it, `pp_stat_o` is 0 and `buf_we_o` is 0, and every register reads back as 0x00. The block starts in the idle state with no register selected.
- R2: A data byte is acted on once, when the synchronised data value changes. Holding a byte for any number of cycles, or writing it again unchanged, produces no further write.
- R3: A byte whose bits 7..5 are 111 (0xE0 | x) ends the current access. It returns the block to idle, drops any staged low nibble and forces `pp_stat_o` to 0.
- R4: A byte whose bits 7..5 are 010 (0x40 | r) latches the offset r = bits 3..0 and enters write mode, but only when the block is idle. The same command in write or read mode is ignored.
- R5: In write mode, a byte 000_0_llll stages the low nibble l. A following byte 000_1_hhhh writes {h,l} to the latched register and clears the stage, and further pairs may follow. A high nibble with no staged low is ignored, as is a write to an offset at or above `NREGS`.
- R6: A byte whose bits 7..5 are 110 (0xC0 | n<<4 | r) selects register r for reading. `pp_stat_o` then carries bits 3..0 of the register when n = 0 and bits 7..4 when n = 1. The value is stable by the third rising clock edge after the byte changes. Offsets at or above `NREGS` read as 0.
- R7: When idle, a byte 000_0_llll stages a low nibble and a following byte 000_1_hhhh commits buffer byte {h,l}. The commit sets `buf_we_o` for exactly one cycle, with `buf_addr_o` equal to the buffer pointer and `buf_wdata_o` equal to {h,l}, and the pointer then advances by one, wrapping at 2^`BUF_AW`. A 16-bit word sent as two pairs, least significant nibble first, lands at two consecutive addresses. A high nibble with no staged low is ignored.
- R8: In read mode, nibble bytes change neither the registers nor the buffer, and the selected nibble stays on `pp_stat_o`.
- R9: Bytes with bits 7..5 equal to 001, 011, 100 or 101 are ignored and leave any staged low nibble in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pp_data_i | input | 8 | Host data lines, asynchronous to `clk` |
| pp_stat_o | output | 4 | Returned nibble, to be placed on status lines 3..6 |
| buf_we_o | output | 1 | One-cycle packet-buffer write strobe |
| buf_addr_o | output | BUF_AW | Packet-buffer address of the committed byte |
| buf_wdata_o | output | 8 | Packet-buffer byte being written |

## Verification
When the host changes the data lines on every clock, a buffer commit from one high-nibble byte and the decode of the next byte fall into the same cycle. The strobe for the committed byte is high while the following low nibble, end or read-select byte is already being acted on. The bench provokes this by driving nibble pairs, then a read-select byte, on consecutive clock periods. It then counts the strobe pulses and records the address and data of each, and checks that both writes landed at consecutive addresses and that the read selection took effect as well. Separately, it checks each write and read one byte at a time, and sweeps every value through one register and every offset through the register file.

// File: rtl/ppn_pkg.sv
package ppn_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    // command codes held in data bits 7..5
    localparam logic [2:0] OP_END   = 3'b111;
    localparam logic [2:0] OP_WADDR = 3'b010;
    localparam logic [2:0] OP_RSEL  = 3'b110;
    localparam logic [2:0] OP_NIB   = 3'b000;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_WRITE = 2'd1,
        M_READ  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        C_END   = 3'd0,
        C_WADDR = 3'd1,
        C_RSEL  = 3'd2,
        C_NIB   = 3'd3,
        C_OTHER = 3'd4
    } cls_e;

endpackage

// File: rtl/ppn_sync.sv
module ppn_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ppn_decode.sv
module ppn_decode
    import ppn_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output cls_e              cls_o,
    output logic              hi_o,
    output logic [NIB_W-1:0]  fld_o
);

    always_comb begin
        unique case (byte_i[7:5])
            OP_END:   cls_o = C_END;
            OP_WADDR: cls_o = C_WADDR;
            OP_RSEL:  cls_o = C_RSEL;
            OP_NIB:   cls_o = C_NIB;
            default:  cls_o = C_OTHER;
        endcase
    end

    assign hi_o  = byte_i[4];
    assign fld_o = byte_i[3:0];

endmodule

// File: rtl/ppn_regfile.sv
module ppn_regfile
    import ppn_pkg::*;
#(
    parameter int NREGS = 12,
    parameter int AW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int SLOTS = 1 << AW;

    logic [BYTE_W-1:0] mem [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NREGS) begin : g_real
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             mem[g] <= '0;
                else if (we_i && (waddr_i == AW'(g)))   mem[g] <= wdata_i;
            end
        end else begin : g_absent
            assign mem[g] = '0;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/ppn_regif.sv
module ppn_regif
    import ppn_pkg::*;
#(
    parameter int NREGS       = 12,
    parameter int BUF_AW      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        pp_data_i,
    output logic [3:0]        pp_stat_o,
    output logic              buf_we_o,
    output logic [BUF_AW-1:0] buf_addr_o,
    output logic [7:0]        buf_wdata_o
);

    localparam int               RA_W     = NIB_W;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = {OP_END, 5'd0};

    typedef struct packed {
        mode_e             mode;
        logic [RA_W-1:0]   ra;
        logic              hi;
        logic              lo_ok;
        logic [NIB_W-1:0]  lo;
        logic [BUF_AW-1:0] ptr;
        logic              we;
        logic [BUF_AW-1:0] wa;
        logic [BYTE_W-1:0] wd;
        logic [BYTE_W-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    logic [BYTE_W-1:0] sync_byte;
    logic              evt;
    cls_e              cls;
    logic              nib_hi;
    logic [NIB_W-1:0]  fld;
    logic              rf_we;
    logic [BYTE_W-1:0] rf_wdata;
    logic [BYTE_W-1:0] rf_rdata;

    ppn_sync #(
        .W       (BYTE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_BYTE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pp_data_i),
        .q_o   (sync_byte)
    );

    ppn_decode dec_i (
        .byte_i (sync_byte),
        .cls_o  (cls),
        .hi_o   (nib_hi),
        .fld_o  (fld)
    );

    ppn_regfile #(
        .NREGS (NREGS),
        .AW    (RA_W)
    ) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .waddr_i (st_q.ra),
        .wdata_i (rf_wdata),
        .raddr_i (st_q.ra),
        .rdata_o (rf_rdata)
    );

    assign evt = (sync_byte != st_q.prev);

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        rf_we    = 1'b0;
        rf_wdata = {fld, st_q.lo};
        if (evt) begin
            st_d.prev = sync_byte;
            unique case (cls)
                C_END: begin
                    st_d.mode  = M_IDLE;
                    st_d.ra    = '0;
                    st_d.hi    = 1'b0;
                    st_d.lo_ok = 1'b0;
                end
                C_WADDR: begin
                    if (st_q.mode == M_IDLE) begin
                        st_d.mode  = M_WRITE;
                        st_d.ra    = fld;
                        st_d.lo_ok = 1'b0;
                    end
                end
                C_RSEL: begin
                    st_d.mode  = M_READ;
                    st_d.ra    = fld;
                    st_d.hi    = nib_hi;
                    st_d.lo_ok = 1'b0;
                end
                C_NIB: begin
                    if (st_q.mode != M_READ) begin
                        if (!nib_hi) begin
                            st_d.lo    = fld;
                            st_d.lo_ok = 1'b1;
                        end else if (st_q.lo_ok) begin
                            st_d.lo_ok = 1'b0;
                            if (st_q.mode == M_WRITE) begin
                                rf_we = 1'b1;
                            end else begin
                                st_d.we  = 1'b1;
                                st_d.wa  = st_q.ptr;
                                st_d.wd  = {fld, st_q.lo};
                                st_d.ptr = st_q.ptr + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= M_IDLE;
            st_q.prev <= IDLE_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.mode == M_READ) pp_stat_o = st_q.hi ? rf_rdata[7:4] : rf_rdata[3:0];
        else                     pp_stat_o = '0;
    end

    assign buf_we_o    = st_q.we;
    assign buf_addr_o  = st_q.wa;
    assign buf_wdata_o = st_q.wd;

endmodule

// File: rtl/ppn_regif_chk.sv
module ppn_regif_chk
    import ppn_pkg::*;
#(
    parameter int BUF_AW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt,
    input mode_e             mode,
    input logic              rf_we,
    input logic [3:0]        pp_stat,
    input logic              buf_we,
    input logic [BUF_AW-1:0] buf_addr
);

    logic              seen_q;
    logic [BUF_AW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (buf_we) begin
            seen_q <= 1'b1;
            last_q <= buf_addr;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!buf_we && (pp_stat == 4'h0)));

    p_strobe_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> !buf_we);

    p_nonread_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != M_READ) |-> (pp_stat == 4'h0));

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> !buf_we);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && seen_q) |-> (buf_addr == BUF_AW'(last_q + 1'b1)));

    p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_READ) |-> (!buf_we && !rf_we));

endmodule

bind ppn_regif ppn_regif_chk #(.BUF_AW(BUF_AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .mode     (st_q.mode),
    .rf_we    (rf_we),
    .pp_stat  (pp_stat_o),
    .buf_we   (buf_we_o),
    .buf_addr (buf_addr_o)
);

// File: tb/ppn_regif_tb_top.sv
`timescale 1ns/1ps
module ppn_regif_tb_top;

    localparam int NREGS  = 12;
    localparam int BUF_AW = 11;
    localparam int BUF_N  = 1 << BUF_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        pp_data = 8'hE0;
    logic [3:0]        pp_stat;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0]        buf_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_ptr = 0;
    int we_cnt = 0;
    int last_a = 0, last_d = 0, prev_a = 0, prev_d = 0;
    logic [7:0] exp_reg [16];
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppn_regif #(.NREGS(NREGS), .BUF_AW(BUF_AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pp_data_i   (pp_data),
        .pp_stat_o   (pp_stat),
        .buf_we_o    (buf_we),
        .buf_addr_o  (buf_addr),
        .buf_wdata_o (buf_wdata)
    );

    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            we_cnt <= we_cnt + 1;
            prev_a <= last_a;
            prev_d <= last_d;
            last_a <= int'(buf_addr);
            last_d <= int'(buf_wdata);
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the third rising edge
    task automatic send(input logic [7:0] b);
        pp_data = b;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input int r, input logic [7:0] v);
        send(8'hE0 | 8'(r));
        send(8'h40 | 8'(r));
        send(8'h40 | 8'(r));
        send({4'h0, v[3:0]});
        send({4'h1, v[7:4]});
        send(8'hE0);
        if (r < NREGS) exp_reg[r] = v;
    endtask

    task automatic rd_reg(input int r, input string rq);
        send(8'hC0 | 8'(r));
        chk(rq, $sformatf("low nibble reg %0d", r), int'(pp_stat), int'(exp_reg[r][3:0]));
        send(8'hD0 | 8'(r));
        chk(rq, $sformatf("high nibble reg %0d", r), int'(pp_stat), int'(exp_reg[r][7:4]));
        send(8'hE0);
        chk("R3", "status after end", int'(pp_stat), 0);
    endtask

    task automatic stream(input logic [7:0] v);
        send({4'h0, v[3:0]});
        chk("R7", "no strobe on low nibble", int'(buf_we), 0);
        send({4'h1, v[7:4]});
        chk("R7", "strobe", int'(buf_we), 1);
        chk("R7", "buffer address", int'(buf_addr), exp_ptr);
        chk("R7", "buffer data", int'(buf_wdata), int'(v));
        exp_ptr = (exp_ptr + 1) % BUF_N;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        int c0;
        for (int i = 0; i < 16; i++) exp_reg[i] = 8'h00;

        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1", "status in reset", int'(pp_stat), 0);
        chk("R1", "strobe in reset", int'(buf_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 16; r++) rd_reg(r, "R1");

        // R5/R6: every offset, including absent ones
        for (int r = 0; r < 16; r++) wr_reg(r, 8'((r * 37 + 11) & 255));
        for (int r = 0; r < 16; r++) rd_reg(r, "R6");

        // R5: all values through one register
        for (int v = 0; v < 256; v++) begin
            wr_reg(5, 8'(v));
            rd_reg(5, "R5");
        end

        // R5: lone high nibble ignored
        send(8'h44); send(8'h1F); send(8'hE0);
        rd_reg(4, "R5");
        // R5: several pairs in one access, last wins
        send(8'h44); send(8'h01); send(8'h12); send(8'h03); send(8'h14); send(8'hE0);
        exp_reg[4] = 8'h43;
        rd_reg(4, "R5");

        // R4: a second write-address command is ignored
        send(8'h42); send(8'h45); send(8'h03); send(8'h1C); send(8'hE0);
        exp_reg[2] = 8'hC3;
        rd_reg(2, "R4");
        rd_reg(5, "R4");

        // R9: other command codes ignored in write mode
        send(8'h42); send(8'h07); send(8'h29); send(8'h9F); send(8'h1E); send(8'hE0);
        exp_reg[2] = 8'hE7;
        rd_reg(2, "R9");

        // R8: read mode ignores nibbles and write-address
        #1 c0 = we_cnt;
        send(8'hC1);
        send(8'h05); send(8'h17); send(8'h42); send(8'h03); send(8'h13);
        chk("R8", "status held", int'(pp_stat), int'(exp_reg[1][3:0]));
        send(8'hE0);
        #1 chk("R8", "no buffer write", we_cnt, c0);
        @(negedge clk);
        rd_reg(1, "R8");
        rd_reg(2, "R8");

        // R7: streaming with wrap
        for (int i = 0; i < BUF_N + 52; i++) stream(8'((i * 13 + 7) & 255));
        // R7: 16-bit word, least significant nibble first
        send(8'h0D); send(8'h1C);
        chk("R7", "word low byte", int'(buf_wdata), 8'hCD);
        chk("R7", "word low addr", int'(buf_addr), exp_ptr);
        exp_ptr = (exp_ptr + 1) % BUF_N;
        send(8'h0B); send(8'h1A);
        chk("R7", "word high byte", int'(buf_wdata), 8'hAB);
        chk("R7", "word high addr", int'(buf_addr), exp_ptr);
        exp_ptr = (exp_ptr + 1) % BUF_N;

        // R9: other code between nibbles keeps the staged low
        send(8'h06); send(8'hA5); send(8'h16);
        chk("R9", "buffer data", int'(buf_wdata), 8'h66);
        chk("R9", "strobe", int'(buf_we), 1);
        exp_ptr = (exp_ptr + 1) % BUF_N;

        // R3: end drops a staged low nibble
        send(8'hE0);
        #1 c0 = we_cnt;
        @(negedge clk);
        send(8'h08); send(8'hE0); send(8'h19); send(8'hE0);
        #1 chk("R3", "staged nibble dropped", we_cnt, c0);
        @(negedge clk);

        // R2: a held byte acts once
        #1 c0 = we_cnt;
        @(negedge clk);
        pp_data = 8'h07;
        repeat (20) @(negedge clk);
        pp_data = 8'h17;
        repeat (20) @(negedge clk);
        send(8'h17);
        send(8'hE0);
        #1 chk("R2", "one write for held bytes", we_cnt, c0 + 1);
        chk("R2", "held write data", last_d, 8'h77);
        exp_ptr = (exp_ptr + 1) % BUF_N;
        @(negedge clk);

        // R7/R6: bytes on consecutive clocks, commit overlaps next decode
        #1 c0 = we_cnt;
        @(negedge clk);
        pp_data = 8'h0A;
        @(negedge clk) pp_data = 8'h1B;
        @(negedge clk) pp_data = 8'h0C;
        @(negedge clk) pp_data = 8'h1D;
        @(negedge clk) pp_data = 8'hC3;
        repeat (6) @(negedge clk);
        #1;
        chk("R7", "back-to-back count", we_cnt, c0 + 2);
        chk("R7", "back-to-back first addr", prev_a, exp_ptr);
        chk("R7", "back-to-back first data", prev_d, 8'hBA);
        chk("R7", "back-to-back second addr", last_a, (exp_ptr + 1) % BUF_N);
        chk("R7", "back-to-back second data", last_d, 8'hDC);
        chk("R6", "read after back-to-back", int'(pp_stat), int'(exp_reg[3][3:0]));
        exp_ptr = (exp_ptr + 2) % BUF_N;
        @(negedge clk);
        send(8'hE0);
        chk("R3", "status after end", int'(pp_stat), 0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

endmodule